// File: doc/BRIEF.md
# Delay-Code Supply Voltage Controller

This block is the digital half of a closed supply-voltage loop. A critical-path replica feeds a 32-tap delay line. Each time a detect edge captures that line, the resulting thermometer pattern reaches the block as one gauge sample. The block turns the sample into a 5-bit delay code and compares the code with a programmable target. It then moves an 8-bit request to an external DC-DC converter up by one step, down by one step, or leaves it unchanged. Request code k stands for 0.9 V + k x 5 mV, so codes 0 to 140 cover 0.9 V to 1.6 V. One gauge digit is worth about 6 mV, which is coarser than the 5 mV request step. A single step therefore cannot jump across the target code, and the loop stays stable.

The block also drives the 6-bit setting word of the replica. In time-share mode it alternates between two stored settings, one per sample, so that two critical paths are measured in turn. The loop then acts on the slower of the pair, which is the one with the smaller code. After every change of the request, a programmable settle count gives the converter time to respond before the next sample is taken.

Gauge samples arrive on a valid/ready pair. A sample is taken only in a cycle where `samp_vld` and `samp_rdy` are both high. Ready is low while the settle count runs. A sample offered during that time is refused, and it does not need to be held, because the next detect edge produces a new one. All other pins are plain levels.

Top module: `dly_vctl`

## Requirements
- R1: The delay code of an accepted sample is the number of consecutive ones counted upward from tap 0 of `samp_therm`. When all 32 taps are one, the count of 32 saturates to 31.
- R2: `bubble_err` goes high with an accepted sample that has a zero at some tap i and a one at tap i+1. The next accepted sample without such a pair clears it.
- R3: On each decision, the request rises by one if the effective code is below `tgt_code`, falls by one if it is above, and holds if it is equal. `vreq` changes only in the cycle after an accepted sample.
- R4: `vreq` stays within 0..140, with code k meaning 0.9 V + k x 5 mV. An up step at 140 and a down step at 0 leave it unchanged.
- R5: With each decision, `v_ok` is updated to the value of (effective code >= `tgt_code`).
- R6: After a decision that changes `vreq`, `samp_rdy` is low for exactly `settle_cycles` cycles. Samples offered while it is low are refused and change no output. With `settle_cycles` = 0, `samp_rdy` stays high.
- R7: While `ts_en` is high, `rep_cfg` starts at `cfg_a` and flips between `cfg_a` and `cfg_b` after each accepted sample. The first sample of a pair only records its code. The second sample decides on the smaller of the two codes. While `ts_en` is low, `rep_cfg` equals `cfg_a` and every accepted sample decides.
- R8: After reset, `vreq` is 140 (1.6 V), `v_ok`, `bubble_err` and `code_out` are 0, and `samp_rdy` is 1.
- R9: `code_out` shows the effective code of the most recent decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld | input | 1 | A captured gauge sample is offered |
| samp_rdy | output | 1 | Block can take a sample (low while settling) |
| samp_therm | input | 32 | Captured delay-line taps, tap 0 at bit 0 |
| tgt_code | input | 5 | Target delay code |
| settle_cycles | input | 8 | Cycles to wait after a request change |
| ts_en | input | 1 | Time-share between two replica settings |
| cfg_a | input | 6 | First replica setting word |
| cfg_b | input | 6 | Second replica setting word |
| rep_cfg | output | 6 | Setting word currently applied to the replica |
| vreq | output | 8 | Voltage request code to the converter |
| v_ok | output | 1 | Last effective code reached the target |
| bubble_err | output | 1 | Last accepted sample had a broken thermometer |
| code_out | output | 5 | Effective code of the last decision |

## Verification
The request can reach the 0 clamp only after 140 down decisions in a row, so the bench feeds a long run of all-ones samples against a zero target to get there and then offers one more. Two other cases can only be observed in the gap after a step. A sample refused while settling is detected by offering a code that would have moved the request and confirming that nothing moved. Time-share pairs are sent in both orders, so the smaller code wins no matter which phase delivers it.

// File: rtl/dvc_pkg.sv
package dvc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/dvc_therm2code.sv
module dvc_therm2code #(
  parameter int TAPS   = 32,
  parameter int CODE_W = 5
) (
  input  logic [TAPS-1:0]   therm,
  output logic [CODE_W-1:0] code,
  output logic              bubble
);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CNT_W-1:0] run_len;
  logic [TAPS-2:0]  gap_hit;

  // Length of the unbroken run of ones starting at tap 0.
  always_comb begin
    logic live;
    live    = 1'b1;
    run_len = '0;
    for (int k = 0; k < TAPS; k++) begin
      if (live && therm[k]) run_len = run_len + 1'b1;
      else                  live    = 1'b0;
    end
  end

  always_comb begin
    if (run_len > CNT_W'(CODE_MAX)) code = CODE_MAX;
    else                            code = run_len[CODE_W-1:0];
  end

  // A zero followed by a one marks a broken thermometer pattern.
  for (genvar g = 0; g < TAPS - 1; g++) begin : g_gap
    assign gap_hit[g] = ~therm[g] & therm[g+1];
  end
  assign bubble = |gap_hit;
endmodule

// File: rtl/dvc_replica_seq.sv
module dvc_replica_seq #(
  parameter int CODE_W = 5,
  parameter int CFG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              ts_en,
  input  logic [CFG_W-1:0]  cfg_a,
  input  logic [CFG_W-1:0]  cfg_b,
  input  logic [CODE_W-1:0] code_in,
  output logic [CFG_W-1:0]  rep_cfg,
  output logic              decide,
  output logic [CODE_W-1:0] eff_code
);
  logic              second;
  logic [CODE_W-1:0] first_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second     <= 1'b0;
      first_code <= '0;
    end else begin
      if (!ts_en)    second <= 1'b0;
      else if (take) second <= ~second;
      if (take && ts_en && !second) first_code <= code_in;
    end
  end

  assign rep_cfg = (ts_en && second) ? cfg_b : cfg_a;
  assign decide  = take && (!ts_en || second);

  always_comb begin
    if (ts_en && second && (first_code < code_in)) eff_code = first_code;
    else                                           eff_code = code_in;
  end
endmodule

// File: rtl/dvc_vstep.sv
module dvc_vstep
  import dvc_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int VREQ_W = 8,
  parameter int VMAX   = 140,
  parameter int SET_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decide,
  input  logic [CODE_W-1:0] eff_code,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic [SET_W-1:0]  settle_cycles,
  output logic [VREQ_W-1:0] vreq,
  output logic              v_ok,
  output logic [CODE_W-1:0] code_q,
  output logic              ready
);
  localparam logic [VREQ_W-1:0] TOP = VREQ_W'(VMAX);

  step_e             dir;
  logic [VREQ_W-1:0] nxt;
  logic [SET_W-1:0]  wait_cnt;

  always_comb begin
    if (eff_code < tgt_code)      dir = STEP_UP;
    else if (eff_code > tgt_code) dir = STEP_DOWN;
    else                          dir = STEP_HOLD;
  end

  always_comb begin
    nxt = vreq;
    unique case (dir)
      STEP_UP:   if (vreq < TOP)   nxt = vreq + 1'b1;
      STEP_DOWN: if (vreq != '0)   nxt = vreq - 1'b1;
      default:   nxt = vreq;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vreq     <= TOP;
      v_ok     <= 1'b0;
      code_q   <= '0;
      wait_cnt <= '0;
    end else begin
      if (decide) begin
        vreq   <= nxt;
        v_ok   <= (eff_code >= tgt_code);
        code_q <= eff_code;
      end
      if (decide && (nxt != vreq)) wait_cnt <= settle_cycles;
      else if (wait_cnt != '0)     wait_cnt <= wait_cnt - 1'b1;
    end
  end

  assign ready = (wait_cnt == '0);
endmodule

// File: rtl/dly_vctl.sv
module dly_vctl #(
  parameter int TAPS   = 32,
  parameter int CFG_W  = 6,
  parameter int VREQ_W = 8,
  parameter int VMAX   = 140,
  parameter int SET_W  = 8,
  localparam int CODE_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_vld,
  output logic              samp_rdy,
  input  logic [TAPS-1:0]   samp_therm,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic [SET_W-1:0]  settle_cycles,
  input  logic              ts_en,
  input  logic [CFG_W-1:0]  cfg_a,
  input  logic [CFG_W-1:0]  cfg_b,
  output logic [CFG_W-1:0]  rep_cfg,
  output logic [VREQ_W-1:0] vreq,
  output logic              v_ok,
  output logic              bubble_err,
  output logic [CODE_W-1:0] code_out
);
  logic              take;
  logic [CODE_W-1:0] raw_code;
  logic              raw_bub;
  logic              decide;
  logic [CODE_W-1:0] eff_code;

  assign take = samp_vld && samp_rdy;

  dvc_therm2code #(.TAPS(TAPS), .CODE_W(CODE_W)) u_conv (
    .therm  (samp_therm),
    .code   (raw_code),
    .bubble (raw_bub)
  );

  dvc_replica_seq #(.CODE_W(CODE_W), .CFG_W(CFG_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .ts_en    (ts_en),
    .cfg_a    (cfg_a),
    .cfg_b    (cfg_b),
    .code_in  (raw_code),
    .rep_cfg  (rep_cfg),
    .decide   (decide),
    .eff_code (eff_code)
  );

  dvc_vstep #(.CODE_W(CODE_W), .VREQ_W(VREQ_W), .VMAX(VMAX), .SET_W(SET_W)) u_step (
    .clk           (clk),
    .rst_n         (rst_n),
    .decide        (decide),
    .eff_code      (eff_code),
    .tgt_code      (tgt_code),
    .settle_cycles (settle_cycles),
    .vreq          (vreq),
    .v_ok          (v_ok),
    .code_q        (code_out),
    .ready         (samp_rdy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bubble_err <= 1'b0;
    else if (take) bubble_err <= raw_bub;
  end
endmodule

// File: rtl/dly_vctl_chk.sv
module dly_vctl_chk #(
  parameter int CFG_W  = 6,
  parameter int VREQ_W = 8,
  parameter int VMAX   = 140,
  parameter int SET_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              samp_vld,
  input logic              samp_rdy,
  input logic [SET_W-1:0]  settle_cycles,
  input logic              ts_en,
  input logic [CFG_W-1:0]  cfg_a,
  input logic [CFG_W-1:0]  cfg_b,
  input logic [CFG_W-1:0]  rep_cfg,
  input logic [VREQ_W-1:0] vreq
);
  assert_vreq_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vreq <= VREQ_W'(VMAX));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vreq != $past(vreq)) |->
      ((vreq == $past(vreq) + 1'b1) || (vreq == $past(vreq) - 1'b1)));

  assert_move_needs_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vreq != $past(vreq)) |-> $past(samp_vld && samp_rdy));

  assert_settle_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((vreq != $past(vreq)) && ($past(settle_cycles) != '0)) |-> !samp_rdy);

  assert_cfg_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_en |-> (rep_cfg == cfg_a));

  assert_cfg_choice_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_cfg == cfg_a) || (rep_cfg == cfg_b));
endmodule

bind dly_vctl dly_vctl_chk #(
  .CFG_W(CFG_W), .VREQ_W(VREQ_W), .VMAX(VMAX), .SET_W(SET_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .samp_vld      (samp_vld),
  .samp_rdy      (samp_rdy),
  .settle_cycles (settle_cycles),
  .ts_en         (ts_en),
  .cfg_a         (cfg_a),
  .cfg_b         (cfg_b),
  .rep_cfg       (rep_cfg),
  .vreq          (vreq)
);

// File: tb/dly_vctl_bench.sv
`timescale 1ns/1ps
module dly_vctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_vld = 1'b0;
  logic        samp_rdy;
  logic [31:0] samp_therm = '0;
  logic [4:0]  tgt_code = '0;
  logic [7:0]  settle_cycles = '0;
  logic        ts_en = 1'b0;
  logic [5:0]  cfg_a = 6'h11;
  logic [5:0]  cfg_b = 6'h2A;
  logic [5:0]  rep_cfg;
  logic [7:0]  vreq;
  logic        v_ok;
  logic        bubble_err;
  logic [4:0]  code_out;

  int checks = 0;
  int failures = 0;
  int exp_v = 140;

  always #2.5 clk = ~clk;

  dly_vctl u_dly_vctl (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_rdy(samp_rdy),
    .samp_therm(samp_therm), .tgt_code(tgt_code), .settle_cycles(settle_cycles),
    .ts_en(ts_en), .cfg_a(cfg_a), .cfg_b(cfg_b), .rep_cfg(rep_cfg),
    .vreq(vreq), .v_ok(v_ok), .bubble_err(bubble_err), .code_out(code_out)
  );

  // therm, target, expected code, expected bubble
  localparam logic [42:0] VEC [0:8] = '{
    {32'h0000_000F, 5'd20, 5'd4,  1'b0},
    {32'hFFFF_FFFF, 5'd20, 5'd31, 1'b0},
    {32'h0000_03FF, 5'd10, 5'd10, 1'b0},
    {32'h0000_00FF, 5'd10, 5'd8,  1'b0},
    {32'h0000_F0FF, 5'd5,  5'd8,  1'b1},
    {32'h0000_0000, 5'd0,  5'd0,  1'b0},
    {32'hFFFF_FFFE, 5'd3,  5'd0,  1'b1},
    {32'h7FFF_FFFF, 5'd31, 5'd31, 1'b0},
    {32'h0000_0001, 5'd0,  5'd1,  1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of the request rule for one decision.
  task automatic model(input int code, input int tgt);
    if (code < tgt && exp_v < 140) exp_v++;
    else if (code > tgt && exp_v > 0) exp_v--;
  endtask

  // Offer one sample, wait until it is taken; returns at the negedge after.
  task automatic send(input logic [31:0] t);
    while (!samp_rdy) @(negedge clk);
    samp_therm = t;
    samp_vld = 1'b1;
    @(negedge clk);
    samp_vld = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 vreq", vreq, 140);
    chk("R8 v_ok", v_ok, 0);
    chk("R8 bubble", bubble_err, 0);
    chk("R8 code", code_out, 0);
    chk("R8 rdy", samp_rdy, 1);
    chk("R8 rep_cfg", rep_cfg, cfg_a);

    // Vector table: R1 R2 R3 R4 R5 R9
    for (int i = 0; i < 9; i++) begin
      logic [31:0] t;
      int tg, ec, eb;
      t  = VEC[i][42:11];
      tg = VEC[i][10:6];
      ec = VEC[i][5:1];
      eb = VEC[i][0];
      tgt_code = 5'(tg);
      send(t);
      model(ec, tg);
      chk("R1 code", code_out, ec);
      chk("R2 bubble", bubble_err, eb);
      chk("R3 vreq", vreq, exp_v);
      chk("R5 v_ok", v_ok, (ec >= tg) ? 1 : 0);
      chk("R6 rdy with zero settle", samp_rdy, 1);
    end

    // R6: settle window and refused sample
    settle_cycles = 8'd3;
    tgt_code = 5'd10;
    send(32'hFFFF_FFFF);
    model(31, 10);
    chk("R6 step taken", vreq, exp_v);
    chk("R6 rdy low 1", samp_rdy, 0);
    samp_therm = 32'h0;
    samp_vld = 1'b1;
    @(negedge clk);
    samp_vld = 1'b0;
    chk("R6 refused sample vreq", vreq, exp_v);
    chk("R6 refused sample code", code_out, 31);
    chk("R6 rdy low 2", samp_rdy, 0);
    @(negedge clk);
    chk("R6 rdy low 3", samp_rdy, 0);
    @(negedge clk);
    chk("R6 rdy back", samp_rdy, 1);
    settle_cycles = 8'd0;

    // R7: time-share pairs
    ts_en = 1'b1;
    tgt_code = 5'd10;
    @(negedge clk);
    chk("R7 start cfg_a", rep_cfg, cfg_a);
    send(32'h000F_FFFF);
    chk("R7 first of pair holds", vreq, exp_v);
    chk("R7 cfg_b", rep_cfg, cfg_b);
    send(32'h0000_001F);
    model(5, 10);
    chk("R7 min of pair (later)", code_out, 5);
    chk("R7 vreq", vreq, exp_v);
    chk("R7 back to cfg_a", rep_cfg, cfg_a);
    send(32'h0000_001F);
    send(32'h000F_FFFF);
    model(5, 10);
    chk("R7 min of pair (earlier)", code_out, 5);
    chk("R7 vreq 2", vreq, exp_v);
    send(32'h0000_0FFF);
    send(32'h0000_7FFF);
    model(12, 10);
    chk("R7 min of pair above tgt", code_out, 12);
    chk("R7 vreq 3", vreq, exp_v);
    ts_en = 1'b0;
    @(negedge clk);
    chk("R7 plain cfg_a", rep_cfg, cfg_a);

    // R4: drive to the lower clamp
    tgt_code = 5'd0;
    for (int n = 0; n < 145; n++) send(32'hFFFF_FFFF);
    chk("R4 lower clamp", vreq, 0);
    send(32'hFFFF_FFFF);
    chk("R4 stays at 0", vreq, 0);
    chk("R5 v_ok at clamp", v_ok, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule